// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target with Bus Timeout

This block is the bus side of an I2C target that gives a host access to a 64-byte, 8-bit-wide storage space through an internal byte pointer. A write transaction loads the pointer from its first data byte. Any further bytes in that transaction are stored at consecutive addresses. A read transaction returns bytes starting at the pointer, most significant bit first, and advances the pointer after each byte. To start a read at a chosen address, the host sends a write that carries only the pointer byte, then a repeated START and a read header.

SCL and SDA are brought into the system clock domain through a two-flop synchronizer. START and STOP are recognised as SDA edges while SCL is high. The block never drives SCL. On SDA it only pulls the line low (open drain). A watchdog counts timeout ticks while SCL stays low and the oscillator-enable input is high. When the count reaches its limit, the bus engine returns to idle and releases SDA. The storage itself sits outside the block and is reached through a simple memory port with combinational read data.

Top module: `i2c_mem_target`

## Requirements
- R1: A header whose upper 7 bits equal the DEV_ADDR parameter (default 7'h68) is acknowledged by pulling SDA low during the ninth clock. A header with any other address is not acknowledged, and the block then ignores the bus (no acknowledge, no write) until the next START or STOP.
- R2: In a write transaction, the first byte after the header loads the pointer from its low 6 bits. Each later byte is written to the pointer address, and the pointer then advances. Every byte is acknowledged.
- R3: A write carrying only the pointer byte, followed by a repeated START (with no STOP) and a read header (R/W bit 1), makes the first byte read come from that pointer.
- R4: Read bytes are sent MSB first. A master acknowledge after a byte makes the block send the byte at the next address.
- R5: A master not-acknowledge after a read byte makes the block release SDA and stay released until the next START.
- R6: The pointer wraps from 63 to 0 when it advances, for both writes and reads.
- R7: When SCL stays low for TO_TICKS (default 16) timeout ticks with the oscillator enable high, the engine returns to idle and releases SDA, even in the middle of driving a 0 bit. A following START is accepted normally.
- R8: SCL held low for fewer than TO_TICKS ticks causes no timeout, and the transaction in progress completes normally.
- R9: While the oscillator enable is low, the timeout count does not advance, so a long SCL low phase does not release a driven SDA.
- R10: After reset, SDA is released and no memory write is issued.
- R11: A STOP returns the engine to idle. Bytes clocked after it without a new START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| tick_i | input | 1 | Timeout time-base strobe, one clock wide |
| osc_en_i | input | 1 | Oscillator enable; gates the timeout count |
| mem_addr_o | output | 6 | Memory address (current pointer) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one clock wide |
| mem_rdata_i | input | 8 | Memory read data at mem_addr_o, combinational |

## Verification
The bench drives these transaction patterns:
- A pointer-plus-data write, whose stored values and addresses a scoreboard checks against the memory port.
- A dummy write followed by a repeated START and a three-byte read ended by a NACK. This separates pointer loading from auto-increment, and shows whether SDA is released afterwards.
- A foreign-address header and stray bytes after a STOP. These tell a true ignore apart from a late acknowledge.
- A write and a read across address 63. These expose any pointer width or wrap error.
- SCL low phases that are short, long, and long with the oscillator enable off, each taken while the block is pulling SDA. These separate the timeout limit from its gating.

// File: rtl/i2c_mem_pkg.sv
// Package: shared state encoding for the I2C memory target.
// Assumes: one 8-bit byte per bus transfer.
package i2c_mem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for START
        ST_HDR,      // shifting in the address header
        ST_HDR_ACK,  // driving the header acknowledge
        ST_WR_BYTE,  // receiving a pointer or data byte
        ST_WR_ACK,   // driving the data acknowledge
        ST_RD_BYTE,  // transmitting a data byte
        ST_RD_ACK,   // sampling the master acknowledge
        ST_IGNORE    // off the bus until START or STOP
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL/SDA into the clock domain and flags SCL edges,
// START and STOP. Assumes the lines idle high; resets to that level.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_o      = scl_ff[STAGES-1];
        sda_o      = sda_ff[STAGES-1];
        scl_rise_o = scl_o & ~scl_prev;
        scl_fall_o = ~scl_o & scl_prev;
        start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
        stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
    end

    // R11
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/i2c_scl_timeout.sv
// Module: counts timeout ticks while SCL is low and the oscillator is
// enabled; emits a one-cycle pulse when the limit is reached.
// Assumes tick_i is a one-cycle strobe. Clears whenever SCL is high.
module i2c_scl_timeout #(
    parameter int TO_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_low_i,
    input  logic tick_i,
    input  logic osc_en_i,
    output logic timeout_o
);
    localparam int CW = $clog2(TO_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TO_TICKS);

    logic [CW-1:0] cnt;
    logic          step;

    assign step = scl_low_i && osc_en_i && tick_i && (cnt != LIMIT);

    // Tick counter with saturation and a registered limit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            timeout_o <= 1'b0;
        end else begin
            timeout_o <= step && (cnt == LIMIT - 1'b1);
            if (!scl_low_i)
                cnt <= '0;
            else if (step)
                cnt <= cnt + 1'b1;
        end
    end

    // R9
    osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low_i && !osc_en_i) |=> $stable(cnt));
    // R8
    low_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> $past(scl_low_i));
endmodule

// File: rtl/i2c_mem_fsm.sv
// Module: bit-level I2C target engine with byte pointer and memory port.
// Assumes synchronized SCL edges and START/STOP flags. Changes SDA only
// after SCL falls. Never holds SCL.
module i2c_mem_fsm
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              timeout_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam logic [3:0] BITS = 4'd8;

    bus_state_t        st;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic [ADDR_W-1:0] ptr;
    logic              rw;
    logic              ptr_phase;
    logic              mack;

    assign mem_addr_o = ptr;

    // Transaction state, shift register, pointer and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            shreg       <= '0;
            bitcnt      <= '0;
            ptr         <= '0;
            rw          <= 1'b0;
            ptr_phase   <= 1'b0;
            mack        <= 1'b0;
            sda_pull_o  <= 1'b0;
            mem_we_o    <= 1'b0;
            mem_wdata_o <= '0;
        end else begin
            mem_we_o <= 1'b0;
            if (mem_we_o)
                ptr <= ptr + 1'b1;
            if (timeout_i || stop_i) begin
                st         <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else if (start_i) begin
                st         <= ST_HDR;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
                ptr_phase  <= 1'b1;
            end else begin
                case (st)
                    ST_HDR: begin
                        if (scl_rise_i) begin
                            shreg  <= {shreg[6:0], sda_s_i};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall_i && bitcnt == BITS) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                sda_pull_o <= 1'b1;
                                rw         <= shreg[0];
                                st         <= ST_HDR_ACK;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    ST_HDR_ACK: begin
                        if (scl_fall_i) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg      <= mem_rdata_i;
                                sda_pull_o <= ~mem_rdata_i[7];
                                st         <= ST_RD_BYTE;
                            end else begin
                                sda_pull_o <= 1'b0;
                                st         <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise_i) begin
                            shreg  <= {shreg[6:0], sda_s_i};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall_i && bitcnt == BITS) begin
                            sda_pull_o <= 1'b1;
                            st         <= ST_WR_ACK;
                            if (ptr_phase) begin
                                ptr       <= shreg[ADDR_W-1:0];
                                ptr_phase <= 1'b0;
                            end else begin
                                mem_we_o    <= 1'b1;
                                mem_wdata_o <= shreg;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall_i) begin
                            sda_pull_o <= 1'b0;
                            bitcnt     <= '0;
                            st         <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise_i) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall_i) begin
                            if (bitcnt == BITS) begin
                                sda_pull_o <= 1'b0;
                                ptr        <= ptr + 1'b1;
                                st         <= ST_RD_ACK;
                            end else begin
                                sda_pull_o <= ~shreg[6];
                                shreg      <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise_i) begin
                            mack <= ~sda_s_i;
                        end else if (scl_fall_i) begin
                            if (mack) begin
                                shreg      <= mem_rdata_i;
                                sda_pull_o <= ~mem_rdata_i[7];
                                bitcnt     <= '0;
                                st         <= ST_RD_BYTE;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> (!sda_pull_o && st == ST_IDLE));
    // R1
    ignore_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !mem_we_o);
    // R6
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));
    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_ACK && scl_fall_i && !mack && !start_i && !stop_i && !timeout_i)
            |=> (!sda_pull_o && st == ST_IGNORE));
endmodule

// File: rtl/i2c_mem_target.sv
// Module: top of the I2C memory target. Joins line synchronizer, SCL-low
// watchdog and bus engine. Assumes an external 2**ADDR_W x 8 memory with
// combinational read data. Drives SDA only as an open-drain pull.
module i2c_mem_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         ADDR_W      = 6,
    parameter int         TO_TICKS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              tick_i,
    input  logic              osc_en_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, timeout;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    i2c_scl_timeout #(.TO_TICKS(TO_TICKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .scl_low_i(~scl_s), .tick_i(tick_i),
        .osc_en_i(osc_en_i), .timeout_o(timeout)
    );

    i2c_mem_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
        .timeout_i(timeout), .sda_pull_o(sda_pull_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sda_pull_o && !mem_we_o));
endmodule

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
    localparam int Q = 5;
    localparam logic [6:0] DEV = 7'h68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic tick = 1'b0;
    logic osc_en = 1'b1;
    logic sda_pull;
    logic [5:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic mem_we;
    logic sda_line;
    logic [7:0] mem [64];

    int n_chk = 0;
    int n_fail = 0;
    int tcnt = 0;

    typedef struct { logic [5:0] a; logic [7:0] d; } wr_t;
    wr_t exp_wr[$];

    always #2 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign mem_rdata = mem[mem_addr];

    i2c_mem_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .tick_i(tick), .osc_en_i(osc_en),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
        .mem_rdata_i(mem_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Timeout tick every 8 clocks, driven away from the active edge.
    always @(negedge clk) begin
        tcnt <= (tcnt == 7) ? 0 : tcnt + 1;
        tick <= (tcnt == 7);
    end

    // Memory model and scoreboard monitor for writes.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R2 unexpected write", int'(mem_addr), 0);
            end else begin
                wr_t e;
                e = exp_wr.pop_front();
                check(mem_addr == e.a, "R2/R6 write addr", int'(mem_addr), int'(e.a));
                check(mem_wdata == e.d, "R2 write data", int'(mem_wdata), int'(e.d));
            end
            mem[mem_addr] = mem_wdata;
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    waitq(Q);
        scl_m = 1'b1; waitq(2 * Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        ack = !sda_line; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; waitq(Q);
            scl_m = 1'b1; waitq(Q);
            d[i] = sda_line; waitq(Q);
            scl_m = 1'b0; waitq(Q);
        end
        send_bit(!mack);
    endtask

    task automatic push_wr(input logic [5:0] a, input logic [7:0] d);
        wr_t e;
        e.a = a; e.d = d;
        exp_wr.push_back(e);
    endtask

    // Header plus pointer byte, then repeated START and read header.
    task automatic point_and_read(input logic [5:0] p, output bit ack);
        bit a;
        bus_start();
        write_byte({DEV, 1'b0}, a);
        write_byte({2'b00, p}, a);
        bus_start();
        write_byte({DEV, 1'b1}, ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        waitq(5);
        // R10: reset state
        check(!sda_pull && !mem_we, "R10 reset quiet", int'(sda_pull), 0);
        rst_n = 1'b1;
        waitq(10);
        check(!sda_pull, "R10 released after reset", int'(sda_pull), 0);

        // R1, R2: pointer then two data bytes
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R1 header ack", int'(ack), 1);
        write_byte(8'h10, ack);
        check(ack, "R2 pointer ack", int'(ack), 1);
        push_wr(6'h10, 8'h3C);
        write_byte(8'h3C, ack);
        check(ack, "R2 data ack", int'(ack), 1);
        push_wr(6'h11, 8'h81);
        write_byte(8'h81, ack);
        bus_stop();
        waitq(4 * Q);
        check(exp_wr.size() == 0, "R2 all writes seen", exp_wr.size(), 0);

        // R3, R4, R5: dummy write, repeated START, 3-byte read
        point_and_read(6'h10, ack);
        check(ack, "R3 read header ack", int'(ack), 1);
        read_byte(1'b1, d);
        check(d == 8'h3C, "R3 first byte from pointer", int'(d), 'h3C);
        read_byte(1'b1, d);
        check(d == 8'h81, "R4 next byte", int'(d), 'h81);
        read_byte(1'b0, d);
        check(d == 8'(18 * 7 + 3), "R4 third byte", int'(d), 18 * 7 + 3);
        waitq(4 * Q);
        check(!sda_pull, "R5 released after NACK", int'(sda_pull), 0);
        bus_stop();

        // R1: foreign address ignored
        bus_start();
        write_byte({7'h23, 1'b0}, ack);
        check(!ack, "R1 foreign header nack", int'(ack), 0);
        write_byte(8'h00, ack);
        check(!ack, "R1 bus ignored", int'(ack), 0);
        bus_stop();

        // R6: wrap on write and on read
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'd63, ack);
        push_wr(6'd63, 8'h5A);
        write_byte(8'h5A, ack);
        push_wr(6'd0, 8'h6B);
        write_byte(8'h6B, ack);
        check(ack, "R6 ack after wrap", int'(ack), 1);
        bus_stop();
        point_and_read(6'd63, ack);
        read_byte(1'b1, d);
        check(d == 8'h5A, "R6 read at 63", int'(d), 'h5A);
        read_byte(1'b0, d);
        check(d == 8'h6B, "R6 read wraps to 0", int'(d), 'h6B);
        bus_stop();

        // R8: short SCL-low stretch by the master
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h20, ack);
        waitq(80);
        push_wr(6'h20, 8'h77);
        write_byte(8'h77, ack);
        check(ack, "R8 no timeout on short low", int'(ack), 1);
        bus_stop();
        waitq(4 * Q);
        check(exp_wr.size() == 0, "R8 write landed", exp_wr.size(), 0);

        // R7: long low while driving a 0 bit (mem[5] = 0x26)
        point_and_read(6'd5, ack);
        check(sda_pull, "R7 driving bit7=0", int'(sda_pull), 1);
        waitq(200);
        check(!sda_pull, "R7 timeout released SDA", int'(sda_pull), 0);
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R7 new START accepted", int'(ack), 1);
        bus_stop();

        // R9: oscillator disabled keeps SDA driven
        point_and_read(6'd5, ack);
        osc_en = 1'b0;
        waitq(300);
        check(sda_pull, "R9 no timeout while disabled", int'(sda_pull), 1);
        osc_en = 1'b1;
        waitq(200);
        check(!sda_pull, "R9 timeout after enable", int'(sda_pull), 0);
        bus_stop();

        // R11: STOP returns to idle; stray byte is not acknowledged
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        write_byte(8'h30, ack);
        bus_stop();
        scl_m = 1'b0; waitq(Q);
        write_byte({DEV, 1'b0}, ack);
        check(!ack, "R11 idle after STOP", int'(ack), 0);
        bus_stop();
        waitq(20);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule